// File: doc/BRIEF.md
# PHY Register Handshake Access Master

This block is a hardware sequencer that reads and writes 16-bit registers inside a PHY whose registers are not memory-mapped. The PHY sees only one 32-bit control word, driven by this block, and returns one 32-bit status word. The status word carries read data and an acknowledge flag. Each access is split into phases: address capture, then data capture (writes only), then a read or write strobe. Every phase is a four-phase handshake: the block raises a strobe, waits for the acknowledge to rise, drops the strobe and waits for the acknowledge to fall.

A client issues a request with an address, write data and a read/write select. The block reports a one-cycle done pulse, or a one-cycle timeout error if the PHY fails to answer. Read results appear on a held output. The acknowledge passes through a two-flop synchroniser. It is sampled once per wait interval, counted in clock cycles, and each wait allows only a bounded number of samples.

Top module: `phy_hs_master`

## Requirements
- R1: After reset, busy, done, timeout_err, rd_data and the whole control word are zero.
- R2: Control word layout: payload (address or data) in bits 15:0, capture-address strobe bit 16, capture-data strobe bit 17, write strobe bit 18, read strobe bit 19, bits 31:20 zero. The status word carries read data in bits 15:0 and the acknowledge in bit 16.
- R3: Every access begins with this control word sequence: the address alone, then the address with bit 16 (held until ack is 1), then the address alone (held until ack is 0).
- R4: A write continues with this sequence: the data alone, then the data with bit 17 (until ack is 1), then the data alone (until ack is 0).
- R5: A write ends with bit 18 alone (until ack is 1), then the data alone (until ack is 0), then an all-zero word together with a done pulse.
- R6: A read continues after the address phase with bit 19 alone (until ack is 1). At that point status bits 15:0 are captured into rd_data. The word then goes to all zeros (until ack is 0) and done pulses. rd_data holds its value until the next read.
- R7: The synchronised acknowledge is sampled once at the end of each WAIT_CYCLES interval, up to MAX_POLLS times per wait. If the expected level never appears, timeout_err pulses, the control word returns to zero and the block goes idle. With WAIT_CYCLES=8 and MAX_POLLS=10, a PHY that never acknowledges gives the error on the 82nd falling clock edge after the request was driven.
- R8: A request is accepted only while busy is low. busy rises in the cycle after acceptance and falls in the cycle that done or timeout_err pulses; done and timeout_err never pulse together. A request presented while busy has no effect.
- R9: At most one of control bits 19:16 is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout_err | output | 1 | One-cycle pulse when an acknowledge wait is exhausted |
| rd_data | output | 16 | Result of the last successful read |
| phy_ctrl | output | 32 | Control word to the PHY |
| phy_stat | input | 32 | Status word from the PHY |

## Verification
Most wrong internal states show up at once in the control word. A skipped, repeated or reordered phase changes the sequence of distinct values it takes, so the bench logs every change and compares the log with the expected sequence for each access. A miscounted poll or interval changes the cycle on which a silent PHY produces the error, and the bench checks that edge exactly. A wrongly sampled read, or a late request that slips through while busy, shows up only on a later read-back. A stuck state shows as a missing done within the bench's bound.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

    localparam int unsigned HW_W = 16;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADR_DRV,
        S_ADR_CAP,
        S_ADR_REL,
        S_DAT_DRV,
        S_DAT_CAP,
        S_DAT_REL,
        S_WR_STB,
        S_WR_REL,
        S_RD_STB,
        S_RD_REL
    } seq_e;

    typedef struct packed {
        seq_e             st;
        logic [31:0]      ctrl;
        logic [HW_W-1:0]  addr;
        logic [HW_W-1:0]  wdata;
        logic             wr;
        logic [HW_W-1:0]  rdata;
        logic             busy;
        logic             done;
        logic             err;
    } seq_s;

    // strobes: bit0 capture-address, bit1 capture-data, bit2 write, bit3 read
    function automatic logic [31:0] ctl_word(input logic [HW_W-1:0] payload,
                                             input logic [3:0] strobes);
        return {12'd0, strobes, payload};
    endfunction

    function automatic logic want_high(input seq_e s);
        return (s == S_ADR_CAP) || (s == S_DAT_CAP) || (s == S_WR_STB) || (s == S_RD_STB);
    endfunction

endpackage

// File: rtl/phy_hs_sync.sv
module phy_hs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/phy_hs_pacer.sv
module phy_hs_pacer #(
    parameter int unsigned WAIT_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CNT_W = (WAIT_CYCLES > 2) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WAIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart || (cnt_q == '0)) cnt_d = RELOAD;
        else                          cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RELOAD;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == '0);

    // R7
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/phy_hs_master.sv
module phy_hs_master
    import phy_hs_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 50,
    parameter int unsigned MAX_POLLS   = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic        timeout_err,
    output logic [15:0] rd_data,
    output logic [31:0] phy_ctrl,
    input  logic [31:0] phy_stat
);
    localparam int unsigned POLL_W = $clog2(MAX_POLLS + 1);
    localparam logic [POLL_W-1:0] LAST_POLL = POLL_W'(MAX_POLLS - 1);

    seq_s              cur, nx;
    logic [POLL_W-1:0] polls_d, polls_q;
    logic              ack_s, tick, restart;

    logic unused_stat;
    assign unused_stat = ^phy_stat[31:17];

    phy_hs_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(phy_stat[16]), .dout(ack_s)
    );

    phy_hs_pacer #(.WAIT_CYCLES(WAIT_CYCLES)) u_pacer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    always_comb begin
        nx      = cur;
        nx.done = 1'b0;
        nx.err  = 1'b0;
        polls_d = polls_q;
        case (cur.st)
            S_IDLE: begin
                if (req_valid) begin
                    nx.busy  = 1'b1;
                    nx.addr  = req_addr;
                    nx.wdata = req_wdata;
                    nx.wr    = req_write;
                    nx.ctrl  = ctl_word(req_addr, 4'b0000);
                    nx.st    = S_ADR_DRV;
                end
            end
            S_ADR_DRV: begin
                nx.ctrl = ctl_word(cur.addr, 4'b0001);
                nx.st   = S_ADR_CAP;
            end
            S_DAT_DRV: begin
                nx.ctrl = ctl_word(cur.wdata, 4'b0010);
                nx.st   = S_DAT_CAP;
            end
            default: begin
                if (tick) begin
                    if (ack_s == want_high(cur.st)) begin
                        polls_d = '0;
                        case (cur.st)
                            S_ADR_CAP: begin
                                nx.ctrl = ctl_word(cur.addr, 4'b0000);
                                nx.st   = S_ADR_REL;
                            end
                            S_ADR_REL: begin
                                if (cur.wr) begin
                                    nx.ctrl = ctl_word(cur.wdata, 4'b0000);
                                    nx.st   = S_DAT_DRV;
                                end else begin
                                    nx.ctrl = ctl_word('0, 4'b1000);
                                    nx.st   = S_RD_STB;
                                end
                            end
                            S_DAT_CAP: begin
                                nx.ctrl = ctl_word(cur.wdata, 4'b0000);
                                nx.st   = S_DAT_REL;
                            end
                            S_DAT_REL: begin
                                nx.ctrl = ctl_word('0, 4'b0100);
                                nx.st   = S_WR_STB;
                            end
                            S_WR_STB: begin
                                nx.ctrl = ctl_word(cur.wdata, 4'b0000);
                                nx.st   = S_WR_REL;
                            end
                            S_RD_STB: begin
                                nx.rdata = phy_stat[15:0];
                                nx.ctrl  = '0;
                                nx.st    = S_RD_REL;
                            end
                            default: begin
                                nx.ctrl = '0;
                                nx.busy = 1'b0;
                                nx.done = 1'b1;
                                nx.st   = S_IDLE;
                            end
                        endcase
                    end else if (polls_q == LAST_POLL) begin
                        polls_d = '0;
                        nx.ctrl = '0;
                        nx.busy = 1'b0;
                        nx.err  = 1'b1;
                        nx.st   = S_IDLE;
                    end else begin
                        polls_d = polls_q + 1'b1;
                    end
                end
            end
        endcase
        restart = (nx.st != cur.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= '{st: S_IDLE, default: '0};
            polls_q <= '0;
        end else begin
            cur     <= nx;
            polls_q <= polls_d;
        end
    end

    assign busy        = cur.busy;
    assign done        = cur.done;
    assign timeout_err = cur.err;
    assign rd_data     = cur.rdata;
    assign phy_ctrl    = cur.ctrl;

    // R9
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_ctrl[19:16]));
    // R8
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout_err));
    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout_err) |-> !busy);
    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);
    // R7
    err_ctrl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (phy_ctrl == 32'd0));
    // R7
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        polls_q < POLL_W'(MAX_POLLS));
    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur.st == S_RD_STB && tick && ack_s) |=> $stable(rd_data));
endmodule

// File: tb/tb_phy_hs_master.sv
module tb_phy_hs_master;
    localparam int unsigned W = 8;
    localparam int unsigned NP = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, timeout_err;
    logic [15:0] rd_data;
    logic [31:0] phy_ctrl, phy_stat;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    phy_hs_master #(.WAIT_CYCLES(W), .MAX_POLLS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .timeout_err(timeout_err), .rd_data(rd_data), .phy_ctrl(phy_ctrl),
        .phy_stat(phy_stat)
    );

    // PHY responder model
    int          lat = 3;
    int          mode = 0;   // 0 normal, 1 never acks, 2 ack never falls
    int          dly = 0;
    logic        ack = 1'b0;
    logic [15:0] m_addr = '0, m_data = '0;
    logic [15:0] mem [256];
    logic        want;

    initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

    always_comb begin
        want = |phy_ctrl[19:16];
        if (mode == 1) want = 1'b0;
        if (mode == 2) want = want | ack;
    end

    always @(posedge clk) begin
        if (ack != want) begin
            if (dly >= lat) begin
                ack <= want;
                dly <= 0;
                if (want) begin
                    if (phy_ctrl[16]) m_addr <= phy_ctrl[15:0];
                    if (phy_ctrl[17]) m_data <= phy_ctrl[15:0];
                    if (phy_ctrl[18]) mem[m_addr[7:0]] <= m_data;
                end
            end else begin
                dly <= dly + 1;
            end
        end else begin
            dly <= 0;
        end
    end

    assign phy_stat = {15'd0, ack, (phy_ctrl[19] ? mem[m_addr[7:0]] : 16'h0000)};

    // control word change log
    logic [31:0] log_q[$];
    logic [31:0] prev_ctrl = '0;
    always @(posedge clk) begin
        if (rst_n && phy_ctrl != prev_ctrl) log_q.push_back(phy_ctrl);
        prev_ctrl <= phy_ctrl;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cmp_log(input string tag, input logic [31:0] exp[$]);
        bit ok = (log_q.size() == exp.size());
        int bad = 0;
        if (ok) begin
            for (int i = 0; i < exp.size(); i++) begin
                if (log_q[i] !== exp[i]) begin
                    ok = 0;
                    bad = i;
                    break;
                end
            end
        end
        if (!ok && log_q.size() == exp.size())
            chk(0, tag, log_q[bad], exp[bad]);
        else
            chk(ok, tag, 32'(log_q.size()), 32'(exp.size()));
    endtask

    task automatic onehot_log(input string tag);
        bit ok = 1;
        logic [31:0] badv = '0;
        foreach (log_q[i]) begin
            if ($countones(log_q[i][19:16]) > 1 || log_q[i][31:20] != 0) begin
                ok = 0;
                badv = log_q[i];
            end
        end
        chk(ok, tag, badv, 32'd0);
    endtask

    function automatic logic [31:0] cw(input logic [3:0] s, input logic [15:0] p);
        return {12'd0, s, p};
    endfunction

    // one access: returns done/err seen and falling-edge count
    task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input bit inject, output bit got_done, output bit got_err,
                          output int n, output bit busy_after);
        log_q.delete();
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        busy_after = busy;
        while (!done && !timeout_err && n < 5000) begin
            @(negedge clk);
            n++;
            if (inject && n == 20) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h00AB; req_wdata = 16'h2222;
            end
            if (inject && n == 21) req_valid = 1'b0;
        end
        got_done = done;
        got_err = timeout_err;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_wait(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0 && timeout_err == 0, "R1 reset flags",
            {29'd0, busy, done, timeout_err}, 32'd0);
        chk(phy_ctrl == 0, "R1 reset control word", phy_ctrl, 32'd0);
        chk(rd_data == 0, "R1 reset rd_data", 32'(rd_data), 32'd0);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [15:0] d, input bit inject, input string tag);
        bit gd, ge, ba; int n;
        logic [31:0] exp[$];
        access(1'b1, a, d, inject, gd, ge, n, ba);
        chk(gd && !ge, {tag, " R5 write done"}, {30'd0, gd, ge}, 32'h2);
        chk(ba, {tag, " R8 busy after accept"}, 32'(ba), 32'd1);
        chk(!busy, {tag, " R8 busy low at done"}, 32'(busy), 32'd0);
        exp = '{cw(4'h0, a), cw(4'h1, a), cw(4'h0, a),
                cw(4'h0, d), cw(4'h2, d), cw(4'h0, d),
                cw(4'h4, 16'h0), cw(4'h0, d), 32'd0};
        cmp_log({tag, " R3 R4 R5 write sequence"}, exp);
        onehot_log({tag, " R9 R2 strobe exclusivity"});
        idle_wait(30);
    endtask

    task automatic t_read(input logic [15:0] a, input logic [15:0] expv, input string tag);
        bit gd, ge, ba; int n;
        logic [31:0] exp[$];
        access(1'b0, a, 16'h0, 1'b0, gd, ge, n, ba);
        chk(gd && !ge, {tag, " R6 read done"}, {30'd0, gd, ge}, 32'h2);
        chk(rd_data == expv, {tag, " R6 R2 read data"}, 32'(rd_data), 32'(expv));
        exp = '{cw(4'h0, a), cw(4'h1, a), cw(4'h0, a), cw(4'h8, 16'h0), 32'd0};
        cmp_log({tag, " R3 R6 read sequence"}, exp);
        idle_wait(30);
        chk(rd_data == expv, {tag, " R6 rd_data held"}, 32'(rd_data), 32'(expv));
    endtask

    task automatic t_dead_phy();
        bit gd, ge, ba; int n;
        logic [31:0] exp[$];
        mode = 1;
        access(1'b0, 16'h0055, 16'h0, 1'b0, gd, ge, n, ba);
        chk(ge && !gd, "R7 silent PHY error", {30'd0, gd, ge}, 32'h1);
        chk(n == 10 * W + 2, "R7 timeout edge", 32'(n), 32'(10 * W + 2));
        chk(!busy && phy_ctrl == 0, "R7 idle and zero after timeout", phy_ctrl, 32'd0);
        exp = '{cw(4'h0, 16'h0055), cw(4'h1, 16'h0055), 32'd0};
        cmp_log("R7 timeout sequence", exp);
        mode = 0;
        idle_wait(30);
    endtask

    task automatic t_stuck_ack();
        bit gd, ge, ba; int n;
        logic [31:0] exp[$];
        mode = 2;
        access(1'b1, 16'h0066, 16'h7777, 1'b0, gd, ge, n, ba);
        chk(ge && !gd, "R7 ack never falls error", {30'd0, gd, ge}, 32'h1);
        exp = '{cw(4'h0, 16'h0066), cw(4'h1, 16'h0066), cw(4'h0, 16'h0066), 32'd0};
        cmp_log("R7 abort in release wait", exp);
        mode = 0;
        idle_wait(60);
    endtask

    task automatic t_slow(input int l, input bit expect_ok, input string tag);
        bit gd, ge, ba; int n;
        lat = l;
        access(1'b1, 16'h0077, 16'h4242, 1'b0, gd, ge, n, ba);
        if (expect_ok) chk(gd && !ge, tag, {30'd0, gd, ge}, 32'h2);
        else           chk(ge && !gd, tag, {30'd0, gd, ge}, 32'h1);
        lat = 3;
        idle_wait(150);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle_wait(5);
        t_write(16'h0012, 16'hBEEF, 1'b0, "wr1");
        t_read(16'h0012, 16'hBEEF, "rd1");
        t_write(16'h0034, 16'h1357, 1'b1, "wr_inject");
        t_read(16'h00AB, 16'h0000, "R8 late request ignored");
        t_read(16'h0034, 16'h1357, "rd2");
        t_dead_phy();
        t_read(16'h0034, 16'h1357, "R8 recovery after timeout");
        t_stuck_ack();
        t_slow(60, 1'b1, "R7 slow ack within limit");
        t_read(16'h0077, 16'h4242, "R7 slow write landed");
        t_slow(100, 1'b0, "R7 ack beyond limit times out");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule